// File: doc/BRIEF.md
# Cartridge ROM Segment Bank Mapper

This block translates the 20-bit address of a handheld console CPU into a target memory and a location inside it. The top four address bits pick one of sixteen 64 KB segments. The lowest segment goes to internal RAM and the next one goes to the cartridge save-RAM window. The other fourteen segments are windows onto 64 KB banks of cartridge ROM. The low sixteen address bits pass through unchanged as the offset inside the chosen bank.

Software sets the ROM mapping with byte-wide I/O port writes:

- Segments 2 and 3 each have their own full-byte bank select.
- Segments 4 to 15 share one 4-bit base. Each of these segments uses its own index as the low nibble of its bank number.
- Every bank number is wrapped to the size of the cartridge ROM. The ROM size is given as a power-of-two count of banks.

After reset, a boot-ROM overlay covers the topmost segment. A single write to the release port removes it, and it stays removed until the next reset.

Top module: `rom_seg_mapper`

## Requirements
- R1: The segment is `cpu_addr[19:16]`, and `offset` always equals `cpu_addr[15:0]`. Exactly one of `sel_ram`, `sel_sram`, `sel_rom`, `sel_boot` is high in every cycle.
- R2: Segment 0 asserts `sel_ram` and segment 1 asserts `sel_sram`. For these two segments `sel_rom` and `sel_boot` stay low and `bank` reads 0, whatever the register contents.
- R3: A write to port 0xC2 sets the bank of segment 2 to all 8 data bits. A write to port 0xC3 does the same for segment 3.
- R4: A write to port 0xC0 loads a base from data bits 3:0 and ignores bits 7:4. Segment n, for n from 4 to 14, then maps to bank `(base*16 + n)`.
- R5: `rom_mask` carries the bank count minus one, where the bank count is a power of two from 1 to 256. Every ROM bank number driven on `bank` is ANDed with `rom_mask`.
- R6: After reset, segments 2 and 3 map to bank `rom_mask`. Segment n, for n from 4 to 14, maps to `(0xF0 + n) & rom_mask`. The boot overlay is active.
- R7: While the overlay is active, segment 15 asserts `sel_boot` (not `sel_rom`) with `bank` at 0. Writes to port 0xC0 still update segments 4 to 14 and leave segment 15 on the boot ROM.
- R8: A write to port 0xA0 with data bit 0 set releases the overlay. Segment 15 then maps to `(base*16 + 15) & rom_mask` through `sel_rom`, using the current base. Later writes with bit 0 clear do not bring the overlay back; only reset does.
- R9: A port write takes effect at the clock edge where `io_wr` is sampled, so an access in the next cycle sees the new mapping. Writes to any other port address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | I/O port write strobe |
| io_addr | input | 8 | I/O port address |
| io_data | input | 8 | I/O port write data |
| rom_mask | input | 8 | Cartridge bank count minus one |
| cpu_addr | input | 20 | CPU memory address |
| offset | output | 16 | Byte offset inside the selected 64 KB bank |
| bank | output | 8 | ROM bank number (0 when ROM is not selected) |
| sel_ram | output | 1 | Internal RAM selected |
| sel_sram | output | 1 | Cartridge save RAM selected |
| sel_rom | output | 1 | Cartridge ROM selected |
| sel_boot | output | 1 | Boot ROM selected |

## Verification
The hardest case to reach is segment 15 after the overlay has been released. Its bank depends on a base written at some earlier time, possibly while the overlay was still active. It also has to survive later release-port writes that carry bit 0 clear. To get there, the stimulus writes a base while the boot ROM is still mapped, checks that segment 15 has not moved, then releases the overlay and checks the recomputed bank. It then writes port 0xA0 with bit 0 clear and checks that the mapping does not change. A long mixed phase follows. It interleaves writes to all ports, changes of ROM size and periodic resets. A behavioural model in the bench compares every output in every cycle against this stimulus.

// File: rtl/rom_seg_mapper.sv
module rom_seg_mapper #(
  parameter int ADDR_W = 20,
  parameter int BANK_W = 8,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_RELEASE = 8'hA0,
  parameter logic [PORT_W-1:0] PORT_BASE    = 8'hC0,
  parameter logic [PORT_W-1:0] PORT_SEG2    = 8'hC2,
  parameter logic [PORT_W-1:0] PORT_SEG3    = 8'hC3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_addr,
  input  logic [BANK_W-1:0] io_data,
  input  logic [BANK_W-1:0] rom_mask,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ADDR_W-5:0] offset,
  output logic [BANK_W-1:0] bank,
  output logic              sel_ram,
  output logic              sel_sram,
  output logic              sel_rom,
  output logic              sel_boot
);
  localparam int SEG_W  = 4;
  localparam int BASE_W = BANK_W - SEG_W;
  localparam logic [SEG_W-1:0] TOP_SEG = '1;

  logic [BANK_W-1:0] seg2_q, seg3_q, raw_bank;
  logic [BASE_W-1:0] base_q;
  logic              boot_q;
  logic [SEG_W-1:0]  seg;

  wire wr_base = io_wr && io_addr == PORT_BASE;
  wire wr_seg2 = io_wr && io_addr == PORT_SEG2;
  wire wr_seg3 = io_wr && io_addr == PORT_SEG3;
  wire wr_rel  = io_wr && io_addr == PORT_RELEASE && io_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      seg2_q <= '1;
      seg3_q <= '1;
      base_q <= '1;
      boot_q <= 1'b1;
    end else begin
      if (wr_seg2) seg2_q <= io_data;
      if (wr_seg3) seg3_q <= io_data;
      if (wr_base) base_q <= io_data[BASE_W-1:0];
      if (wr_rel)  boot_q <= 1'b0;
    end
  end

  assign seg    = cpu_addr[ADDR_W-1 -: SEG_W];
  assign offset = cpu_addr[ADDR_W-SEG_W-1:0];

  always_comb begin
    case (seg)
      4'd2:    raw_bank = seg2_q;
      4'd3:    raw_bank = seg3_q;
      default: raw_bank = {base_q, seg};
    endcase
  end

  assign sel_ram  = seg == 4'd0;
  assign sel_sram = seg == 4'd1;
  assign sel_boot = boot_q && seg == TOP_SEG;
  assign sel_rom  = seg > 4'd1 && !sel_boot;
  assign bank     = sel_rom ? (raw_bank & rom_mask) : '0;

  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({sel_ram, sel_sram, sel_rom, sel_boot}) == 1);

  // R2
  low_seg_not_rom_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[ADDR_W-1 -: SEG_W] < 4'd2) |-> (!sel_rom && !sel_boot && bank == '0));

  // R3
  seg2_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_seg2 |=> seg2_q == $past(io_data));

  // R4
  base_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_base |=> base_q == $past(io_data[BASE_W-1:0]));

  // R9
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_base |=> $stable(base_q));

  // R8
  release_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !boot_q |=> !boot_q);

  // R5
  bank_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (bank & ~rom_mask) == '0);
endmodule

// File: tb/rom_seg_mapper_tb.sv
module rom_seg_mapper_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        io_wr = 0;
  logic [7:0]  io_addr = 0;
  logic [7:0]  io_data = 0;
  logic [7:0]  rom_mask = 8'hFF;
  logic [19:0] cpu_addr = 0;
  logic [15:0] offset;
  logic [7:0]  bank;
  logic        sel_ram, sel_sram, sel_rom, sel_boot;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  int m_seg2, m_seg3, m_base;
  bit m_boot;

  always #4 clk = ~clk;

  rom_seg_mapper u_dut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
    .rom_mask(rom_mask), .cpu_addr(cpu_addr), .offset(offset), .bank(bank),
    .sel_ram(sel_ram), .sel_sram(sel_sram), .sel_rom(sel_rom), .sel_boot(sel_boot)
  );

  task automatic model_reset();
    m_seg2 = 255; m_seg3 = 255; m_base = 15; m_boot = 1;
  endtask

  task automatic model_update();
    if (rst) model_reset();
    else if (io_wr) begin
      case (io_addr)
        8'hC2: m_seg2 = int'(io_data);
        8'hC3: m_seg3 = int'(io_data);
        8'hC0: m_base = int'(io_data) % 16;
        8'hA0: if (io_data[0]) m_boot = 0;
        default: ;
      endcase
    end
  endtask

  function automatic string auto_tag(int seg);
    if (seg < 2) return "R2";
    if (seg < 4) return "R3";
    if (seg < 15) return "R4";
    return m_boot ? "R7" : "R8";
  endfunction

  task automatic compare(input string tag);
    int seg, raw, exp_bank;
    logic [3:0] exp_sel, act_sel;
    seg = int'(cpu_addr[19:16]);
    exp_bank = 0;
    if (seg == 0) exp_sel = 4'b0001;
    else if (seg == 1) exp_sel = 4'b0010;
    else if (seg == 15 && m_boot) exp_sel = 4'b1000;
    else begin
      exp_sel = 4'b0100;
      raw = (seg == 2) ? m_seg2 : (seg == 3) ? m_seg3 : m_base * 16 + seg;
      exp_bank = raw & int'(rom_mask);
    end
    act_sel = {sel_boot, sel_rom, sel_sram, sel_ram};
    vectors++;
    if (act_sel !== exp_sel || int'(bank) != exp_bank || offset !== cpu_addr[15:0]) begin
      misses++;
      $display("FAIL %s addr=%h: sel=%b bank=%0d ofs=%h expected sel=%b bank=%0d ofs=%h",
               tag, cpu_addr, act_sel, bank, offset, exp_sel, exp_bank, cpu_addr[15:0]);
    end
  endtask

  // one cycle: drive, check at mid-cycle, advance model after the edge
  task automatic step(input bit r, input bit wr, input logic [7:0] pa, input logic [7:0] pd,
                      input logic [19:0] a, input string tag);
    @(negedge clk);
    rst = r; io_wr = wr; io_addr = pa; io_data = pd; cpu_addr = a;
    #1;
    if (!r) compare(tag == "" ? auto_tag(int'(a[19:16])) : tag);
    @(posedge clk);
    #1;
    model_update();
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 16; s++) step(0, 0, 8'h00, 8'h00, {s[3:0], 16'h1234 + 16'(s)}, tag);
  endtask

  task automatic do_reset();
    step(1, 0, 0, 0, 0, "");
    step(1, 0, 0, 0, 0, "");
  endtask

  initial begin
    #(8 * 150000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    sweep("R6");                       // reset map, full-size ROM
    sweep("R1");
    rom_mask = 8'h0F; sweep("R5");     // 16-bank ROM
    rom_mask = 8'h03; sweep("R5");
    rom_mask = 8'h00; sweep("R5");
    rom_mask = 8'hFF;
    // R3: full-byte selects, seen in the very next cycle (R9)
    step(0, 1, 8'hC2, 8'hA7, 20'h2_0000, "R3");
    step(0, 0, 0, 0, 20'h2_ABCD, "R9");
    step(0, 1, 8'hC3, 8'h5C, 20'h3_0000, "R3");
    step(0, 0, 0, 0, 20'h3_FFFF, "R3");
    rom_mask = 8'h3F; step(0, 0, 0, 0, 20'h2_0001, "R5");
    rom_mask = 8'hFF;
    // R4: base with junk in upper nibble, while overlay is active (R7)
    step(0, 1, 8'hC0, 8'hB3, 20'h4_0000, "R4");
    sweep("R4");
    step(0, 0, 0, 0, 20'hF_0010, "R7");
    // other ports ignored
    step(0, 1, 8'hC1, 8'h00, 20'h2_0000, "R9");
    step(0, 1, 8'hC4, 8'h11, 20'h5_0000, "R9");
    step(0, 1, 8'hA1, 8'h01, 20'hF_0000, "R9");
    sweep("R9");
    // release port with bit 0 clear: overlay stays
    step(0, 1, 8'hA0, 8'hFE, 20'hF_0000, "R7");
    step(0, 0, 0, 0, 20'hF_0000, "R7");
    // release
    step(0, 1, 8'hA0, 8'h01, 20'hF_0000, "R7");
    step(0, 0, 0, 0, 20'hF_1111, "R8");
    step(0, 1, 8'hA0, 8'h00, 20'hF_0000, "R8");
    step(0, 0, 0, 0, 20'hF_2222, "R8");
    step(0, 1, 8'hC0, 8'h06, 20'hF_0000, "R8");
    step(0, 0, 0, 0, 20'hF_3333, "R8");
    rom_mask = 8'h1F; step(0, 0, 0, 0, 20'hF_3333, "R5");
    rom_mask = 8'hFF;
    // reset brings overlay back
    do_reset();
    sweep("R6");
    // mixed phase
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] pa, pd;
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0: pa = 8'hA0; 1: pa = 8'hC0; 2: pa = 8'hC2; 3: pa = 8'hC3;
        4: pa = 8'hC1; default: pa = 8'(k * 19);
      endcase
      pd = 8'($urandom);
      if (pa == 8'hA0 && $urandom_range(0, 3) != 0) pd[0] = 1'b0;
      if (i % 97 == 0) rom_mask = 8'((1 << $urandom_range(0, 8)) - 1);
      step(i % 701 == 700, $urandom_range(0, 2) == 0, pa, pd, 20'($urandom), "");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule